// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable register-based model of a synchronous pipelined burst memory whose read and write operations may be issued on every clock in any order. No idle cycles are needed between them. Write data travels through the same two-edge pipeline slot that read data uses. The shared data path therefore never has to turn around: a write's data is taken in the same cycle where a read's data would have been driven.

Commands are sampled on enabled rising edges. A load cycle starts a single access or a burst at the address on the bus. A continue cycle advances a two-bit linear burst counter and reuses the direction of the burst in progress. Each of the four 9-bit byte lanes has its own active-low strobe, and the strobe is taken fresh on every write beat. A clock-enable stall freezes the whole block. A sleep input keeps the stored words, blanks the output and turns new commands into deselects. Output enable only gates the drive flag, and it does so combinationally.

Top module: `zbt_sram`

## Requirements
- R1: The word is 36 bits in four 9-bit lanes. Lane k occupies bits [9k+8:9k]. bw_n[k] is active low and writes all 9 bits of lane k; lane A is k=0.
- R2: A read loaded at enabled edge E is driven on rdata, with rvalid high, after the second enabled edge following E. Write data is sampled from wdata at that same second enabled edge. Reads and writes may be issued on consecutive cycles in any mix.
- R3: While cen_n is high, a rising edge is ignored. Burst state, pipeline stages, rdata and the drive state all hold.
- R4: With adv_ld high and a burst active, the low two address bits step by one modulo 4. The upper address bits are kept, the direction is kept, and addr and ce_n are ignored. With adv_ld high and no burst active, the cycle does nothing.
- R5: Byte strobes are sampled on every write beat and apply to that beat's data. If all four strobes are high, that beat stores nothing.
- R6: rvalid stays low in the output slot of a write and of a deselect (load cycle with ce_n high). A deselect starts no array access and ends any burst.
- R7: oe_n high forces rvalid low combinationally. It does not change rdata or the pipeline.
- R8: While sleep is high, rvalid is low, sampled commands act as deselects, array writes are suppressed, and stored contents are kept.
- R9: After synchronous reset rvalid is low, the pipeline is empty and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cen_n | input | 1 | Clock enable, active low; high stalls |
| ce_n | input | 1 | Chip enable, active low, sampled on load cycles |
| adv_ld | input | 1 | High continues the burst, low loads a new address |
| we_n | input | 1 | Write enable, active low, sampled on load cycles |
| bw_n | input | 4 | Per-lane write strobes, active low |
| oe_n | input | 1 | Output enable, active low, gates rvalid |
| sleep | input | 1 | Low-power request, active high |
| addr | input | ADDR_W | Word address |
| wdata | input | 36 | Write data, sampled two enabled edges after its command |
| rdata | output | 36 | Read data register |
| rvalid | output | 1 | Drive flag: rdata is being driven |

## Verification
Three things can fall on one edge: a write committing its data to the array, a read loaded one cycle later to the same word, and a stall or a burst step. The bench provokes this with back-to-back write/read pairs on one address, strobe patterns that change beat by beat inside a burst, and a long constrained-random mix of loads, continues, deselects and stalls. A reference model in the bench advances only on enabled edges. Every cycle it is compared with rvalid, and with rdata whenever a read is due. A mid-cycle toggle of oe_n checks that the drive flag follows output enable without touching rdata.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
    parameter int LANES   = 4;
    parameter int LANE_W  = 9;
    localparam int WORD_W  = LANES * LANE_W;
    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_kind_t;

    typedef struct packed {
        op_kind_t           kind;
        logic [LANES-1:0]   lane_en;
    } op_t;

    localparam op_t OP_EMPTY = '{kind: OP_NONE, lane_en: '0};

    function automatic logic [WORD_W-1:0] lane_merge(
        input logic [WORD_W-1:0] old_w,
        input logic [WORD_W-1:0] new_w,
        input logic [LANES-1:0]  en);
        logic [WORD_W-1:0] r;
        r = old_w;
        for (int k = 0; k < LANES; k++) begin
            if (en[k]) r[k*LANE_W +: LANE_W] = new_w[k*LANE_W +: LANE_W];
        end
        return r;
    endfunction

    function automatic logic [BURST_W-1:0] burst_step(input logic [BURST_W-1:0] b);
        return b + 1'b1;
    endfunction
endpackage

// File: rtl/zbt_cmd.sv
module zbt_cmd
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv_en,
    input  logic              ce_n,
    input  logic              adv_ld,
    input  logic              we_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic              sleep,
    input  logic [ADDR_W-1:0] addr,
    output op_t               s1_op,
    output logic [ADDR_W-1:0] s1_addr
);
    logic              burst_on;
    logic              burst_wr;
    logic [ADDR_W-1:0] cur_addr;
    logic              do_load;
    logic              do_cont;
    logic [ADDR_W-1:0] next_addr;
    op_t               next_op;

    always_comb begin
        do_load   = !adv_ld && !ce_n && !sleep;
        do_cont   = adv_ld && burst_on && !sleep;
        next_addr = cur_addr;
        next_op   = OP_EMPTY;
        if (do_load) begin
            next_addr    = addr;
            next_op.kind = we_n ? OP_READ : OP_WRITE;
        end else if (do_cont) begin
            next_addr    = {cur_addr[ADDR_W-1:BURST_W], burst_step(cur_addr[BURST_W-1:0])};
            next_op.kind = burst_wr ? OP_WRITE : OP_READ;
        end
        next_op.lane_en = (next_op.kind == OP_WRITE) ? ~bw_n : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            burst_on <= 1'b0;
            burst_wr <= 1'b0;
            cur_addr <= '0;
            s1_op    <= OP_EMPTY;
        end else if (adv_en) begin
            if (do_load) begin
                burst_on <= 1'b1;
                burst_wr <= !we_n;
            end else if (!adv_ld || sleep) begin
                burst_on <= 1'b0;
            end
            cur_addr <= next_addr;
            s1_op    <= next_op;
        end
    end

    assign s1_addr = cur_addr;
endmodule

// File: rtl/zbt_stage.sv
module zbt_stage
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv_en,
    input  op_t               in_op,
    input  logic [ADDR_W-1:0] in_addr,
    output op_t               out_op,
    output logic [ADDR_W-1:0] out_addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_op   <= OP_EMPTY;
            out_addr <= '0;
        end else if (adv_en) begin
            out_op   <= in_op;
            out_addr <= in_addr;
        end
    end
endmodule

// File: rtl/zbt_array.sv
module zbt_array
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv_en,
    input  logic              sleep,
    input  op_t               op,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] q,
    output logic              q_rd
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (adv_en && !rst && op.kind == OP_WRITE && !sleep) begin
            mem[op_addr] <= lane_merge(mem[op_addr], wdata, op.lane_en);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            q_rd <= 1'b0;
        end else if (adv_en) begin
            q_rd <= (op.kind == OP_READ);
            if (op.kind == OP_READ) q <= mem[op_addr];
        end
    end
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cen_n,
    input  logic              ce_n,
    input  logic              adv_ld,
    input  logic              we_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic              oe_n,
    input  logic              sleep,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid
);
    logic              adv_en;
    op_t               s1_op;
    op_t               s2_op;
    logic [ADDR_W-1:0] s1_addr;
    logic [ADDR_W-1:0] s2_addr;
    logic              q_rd;

    assign adv_en = !cen_n;

    zbt_cmd #(.ADDR_W(ADDR_W)) u_cmd (
        .clk(clk), .rst(rst), .adv_en(adv_en), .ce_n(ce_n), .adv_ld(adv_ld),
        .we_n(we_n), .bw_n(bw_n), .sleep(sleep), .addr(addr),
        .s1_op(s1_op), .s1_addr(s1_addr)
    );

    zbt_stage #(.ADDR_W(ADDR_W)) u_stage (
        .clk(clk), .rst(rst), .adv_en(adv_en), .in_op(s1_op), .in_addr(s1_addr),
        .out_op(s2_op), .out_addr(s2_addr)
    );

    zbt_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst(rst), .adv_en(adv_en), .sleep(sleep), .op(s2_op),
        .op_addr(s2_addr), .wdata(wdata), .q(rdata), .q_rd(q_rd)
    );

    assign rvalid = q_rd && !oe_n && !sleep;
endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              cen_n,
    input logic              ce_n,
    input logic              adv_ld,
    input logic              we_n,
    input logic              oe_n,
    input logic              sleep,
    input logic [WORD_W-1:0] rdata,
    input logic              rvalid
);
    assert_read_slot_R2: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && !ce_n && !adv_ld && we_n && !sleep) ##1 !cen_n ##1 !cen_n
        |=> (rvalid || oe_n || sleep));

    assert_stall_hold_R3: assert property (@(posedge clk) disable iff (rst)
        cen_n |=> $stable(rdata));

    assert_write_undriven_R6: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && !ce_n && !adv_ld && !we_n) ##1 !cen_n ##1 !cen_n |=> !rvalid);

    assert_deselect_undriven_R6: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && ce_n && !adv_ld) ##1 !cen_n ##1 !cen_n |=> !rvalid);

    assert_oe_gate_R7: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !rvalid);

    assert_sleep_blank_R8: assert property (@(posedge clk) disable iff (rst)
        sleep |-> !rvalid);

    assert_reset_idle_R9: assert property (@(posedge clk)
        rst |=> !rvalid);
endmodule

bind zbt_sram zbt_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .cen_n(cen_n), .ce_n(ce_n), .adv_ld(adv_ld),
    .we_n(we_n), .oe_n(oe_n), .sleep(sleep), .rdata(rdata), .rvalid(rvalid)
);

// File: tb/test_zbt_sram.sv
module test_zbt_sram;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;
    localparam int MAX_CYC = 150000;

    logic        clk = 1'b0;
    logic        rst;
    logic        cen_n, ce_n, adv_ld, we_n, oe_n, sleep;
    logic [3:0]  bw_n;
    logic [AW-1:0] addr;
    logic [35:0] wdata;
    logic [35:0] rdata;
    logic        rvalid;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;

    // reference model state
    logic [35:0]   m_mem [DEPTH];
    bit            m_bon, m_bwr;
    logic [AW-1:0] m_cur;
    int            m_k1, m_k2;           // 0 none, 1 read, 2 write
    logic [3:0]    m_l1, m_l2;
    logic [AW-1:0] m_a1, m_a2;
    bit            m_ord;
    logic [35:0]   m_q;

    always #(CLK_PERIOD/2) clk = ~clk;

    zbt_sram #(.ADDR_W(AW)) i_zbt_sram (
        .clk(clk), .rst(rst), .cen_n(cen_n), .ce_n(ce_n), .adv_ld(adv_ld),
        .we_n(we_n), .bw_n(bw_n), .oe_n(oe_n), .sleep(sleep), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
    );

    function automatic logic [35:0] merge(input logic [35:0] o, input logic [35:0] n,
                                          input logic [3:0] en);
        logic [35:0] r = o;
        for (int k = 0; k < 4; k++) if (en[k]) r[k*9 +: 9] = n[k*9 +: 9];
        return r;
    endfunction

    task automatic chk1(input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic model_edge();
        bit ld, ct;
        int k;
        if (cen_n) return;                         // R3: stall ignores the edge
        if (m_k2 == 2 && !sleep) m_mem[m_a2] = merge(m_mem[m_a2], wdata, m_l2);  // R1 R5
        m_ord = (m_k2 == 1);
        if (m_k2 == 1) m_q = m_mem[m_a2];
        m_k2 = m_k1; m_l2 = m_l1; m_a2 = m_a1;
        ld = !adv_ld && !ce_n && !sleep;
        ct = adv_ld && m_bon && !sleep;
        k = 0;
        if (ld) begin
            m_bon = 1; m_bwr = !we_n; m_cur = addr; k = we_n ? 1 : 2;
        end else if (ct) begin
            m_cur[1:0] = m_cur[1:0] + 2'd1; k = m_bwr ? 2 : 1;   // R4 wrap
        end else if (!adv_ld || sleep) begin
            m_bon = 0;
        end
        m_k1 = k; m_a1 = m_cur; m_l1 = (k == 2) ? ~bw_n : 4'b0;
    endtask

    task automatic compare(input bit strict);
        bit exp_v;
        exp_v = m_ord && !oe_n && !sleep;
        chk1(sleep ? "R8" : (oe_n ? "R7" : "R2/R6"), {35'b0, rvalid}, {35'b0, exp_v});
        if (exp_v && strict) chk1("R2/R5", rdata, m_q);
    endtask

    task automatic step(input logic c_cen, input logic c_ce, input logic c_adv,
                        input logic c_we, input logic [3:0] c_bw, input logic c_oe,
                        input logic c_slp, input logic [AW-1:0] c_a,
                        input logic [35:0] c_d, input bit probe_oe, input bit strict);
        cen_n = c_cen; ce_n = c_ce; adv_ld = c_adv; we_n = c_we; bw_n = c_bw;
        oe_n = c_oe; sleep = c_slp; addr = c_a; wdata = c_d;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(strict);
        if (probe_oe && m_ord && !sleep) begin
            oe_n = 1'b1; #1;
            chk1("R7 oe high", {35'b0, rvalid}, 36'd0);
            oe_n = 1'b0; #1;
            chk1("R7 oe low", {35'b0, rvalid}, 36'd1);
            chk1("R7 data", rdata, m_q);
        end
    endtask

    // shorthands
    task automatic ld_rd(input logic [AW-1:0] a);
        step(0, 0, 0, 1, 4'hF, 0, 0, a, 36'h0, 0, 1);
    endtask
    task automatic ld_wr(input logic [AW-1:0] a, input logic [3:0] bw, input logic [35:0] d);
        step(0, 0, 0, 0, bw, 0, 0, a, d, 0, 1);
    endtask
    task automatic cont(input logic [3:0] bw, input logic [35:0] d);
        step(0, 1, 1, 1, bw, 0, 0, {AW{1'b1}}, d, 0, 1);
    endtask
    task automatic desel(input logic [35:0] d);
        step(0, 1, 0, 1, 4'hF, 0, 0, '0, d, 0, 1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > MAX_CYC && !done) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected at most %0d", cyc, MAX_CYC);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5A17;
        void'($urandom(seed));
        m_bon = 0; m_bwr = 0; m_cur = '0; m_k1 = 0; m_k2 = 0; m_l1 = 0; m_l2 = 0;
        m_a1 = '0; m_a2 = '0; m_ord = 0; m_q = '0;
        rst = 1; cen_n = 0; ce_n = 1; adv_ld = 0; we_n = 1; bw_n = 4'hF;
        oe_n = 0; sleep = 0; addr = '0; wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        chk1("R9 reset rvalid", {35'b0, rvalid}, 36'd0);
        chk1("R9 reset rdata", rdata, 36'd0);

        // fill every word so later reads are defined
        for (int i = 0; i < DEPTH + 2; i++) begin
            if (i < DEPTH) ld_wr(AW'(i), 4'h0, 36'h0);
            else desel(36'h0);
            if (i >= 2) ; // data for command i-2 is presented on this step
        end
        // above wdata was zero for all; write distinct words now with pipelined data
        for (int i = 0; i < DEPTH + 2; i++) begin
            logic [35:0] d;
            d = {4'hA, 26'(i * 977), 6'(i)};
            if (i < DEPTH) ld_wr(AW'(i), 4'h0, d);
            else desel(d);
        end
        desel(0); desel(0);

        // R2: back-to-back write then read of the same word, then alternating
        ld_wr(6'd5, 4'h0, 36'h0);
        ld_rd(6'd5);
        ld_wr(6'd6, 4'h0, 36'h9_1234_5678);   // data for write to 5
        ld_rd(6'd6);
        ld_rd(6'd5);                           // data slot of write to 6 (wdata unused next)
        step(0, 0, 0, 1, 4'hF, 0, 0, 6'd6, 36'h0, 0, 1);
        desel(0); desel(0); desel(0);

        // R4 R5: write burst from low bits 2, strobes differ per beat, wraps to 0,1
        ld_wr(6'd18, 4'b1110, 36'h0);
        cont(4'b0000, 36'h0);
        cont(4'b1111, 36'h1_1111_1111);       // beat 0 data (lane A only)
        cont(4'b0101, 36'h2_2222_2222);       // beat 1 data (all lanes)
        desel(36'h3_3333_3333);               // beat 2 data (none: abort)
        desel(36'h4_4444_4444);               // beat 3 data (lanes B,D)
        desel(0);
        // R4: read burst from low bits 3 wrapping through the same quad
        ld_rd(6'd19);
        cont(4'hF, 0); cont(4'hF, 0); cont(4'hF, 0);
        desel(0); desel(0); desel(0);

        // R5: write load with every strobe high stores nothing
        ld_wr(6'd40, 4'hF, 0);
        desel(0);
        desel(36'hF_FFFF_FFFF);
        ld_rd(6'd40); desel(0); desel(0); desel(0);

        // R3: stall inside a read burst and inside a write burst
        ld_rd(6'd8);
        step(1, 0, 0, 0, 4'h0, 0, 0, 6'd33, 36'h7, 0, 1);
        cont(4'hF, 0);
        step(1, 1, 0, 0, 4'h0, 0, 0, 6'd1, 36'h7, 0, 1);
        step(1, 1, 0, 0, 4'h0, 0, 0, 6'd1, 36'h7, 0, 1);
        cont(4'hF, 0); desel(0); desel(0); desel(0);
        ld_wr(6'd44, 4'h0, 0);
        step(1, 0, 0, 1, 4'hF, 0, 0, 6'd2, 36'h0, 0, 1);
        desel(0);
        step(1, 0, 0, 1, 4'hF, 0, 0, 6'd2, 36'h8_8888_0000, 0, 1);
        desel(36'h5_A5A5_A5A5);
        ld_rd(6'd44); desel(0); desel(0); desel(0);

        // R4: continue with no burst active does nothing
        desel(0);
        cont(4'h0, 0); cont(4'h0, 0); desel(0); desel(0);

        // R7: oe probes on driven read slots
        ld_rd(6'd12); ld_rd(6'd13); desel(0);
        step(0, 1, 0, 1, 4'hF, 0, 0, 0, 0, 1, 1);
        step(0, 1, 0, 1, 4'hF, 0, 0, 0, 0, 1, 1);
        desel(0);

        // R8: sleep with only reads and deselects in flight
        ld_rd(6'd20); desel(0);
        step(0, 1, 0, 1, 4'hF, 0, 1, 0, 0, 0, 1);
        step(0, 0, 0, 0, 4'h0, 0, 1, 6'd20, 36'hF_0000_000F, 0, 1);
        step(0, 0, 0, 1, 4'hF, 0, 1, 6'd21, 0, 0, 1);
        step(0, 1, 0, 1, 4'hF, 0, 1, 0, 0, 0, 1);
        desel(0);
        ld_rd(6'd20); desel(0); desel(0); desel(0);

        // constrained random mix
        for (int i = 0; i < 6000; i++) begin
            int r;
            logic c_cen, c_ce, c_adv, c_we, c_oe;
            r = $urandom_range(0, 99);
            c_cen = (r < 15);
            c_adv = ($urandom_range(0, 99) < 40);
            c_ce  = ($urandom_range(0, 99) < 10);
            c_we  = $urandom_range(0, 1);
            c_oe  = ($urandom_range(0, 99) < 10);
            step(c_cen, c_ce, c_adv, c_we, 4'($urandom), c_oe, 0, AW'($urandom),
                 {4'($urandom), 32'($urandom)}, ($urandom_range(0, 9) == 0), 1);
        end
        desel(0); desel(0); desel(0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule